// File: doc/BRIEF.md
# Password-Protected Clock Divider

This block turns a fast source clock into a slower output clock. The divide ratio is held in a register. The register accepts a new ratio only when the written word carries a fixed key in its upper bits. A write that lacks the key still has an effect: it forces a known fallback ratio, and it raises a sticky error flag that software must clear explicitly. A second register sets a programmable delay, in source-clock cycles, and an enable for the output. That register has its own 8-bit key. When this key does not match, the output falls back to enabled with no delay.

All state sits in the source-clock domain, and the output is driven from flops. A new ratio waits until the current output period has finished, so every period that appears on the output is complete. Software reaches the block through a single-cycle register port with address, write data, write strobe and combinational read data.

Top module: `pwdiv_top`

## Requirements
- R1: After reset the divide code is 16, the divider register reads 0xAB0, the phase register reads 0xAA8 (enabled, delay 0), and the status register reads 0.
- R2: A write to address 0 whose value lies in 0xAA0..0xABF (bits [31:5] equal 0x55) stores bits [4:0] as the divide code. The divider register then reads back 0xAA0 plus the code.
- R3: For codes 1 to 31 the output period is exactly the code, in source cycles. The high phase lasts floor(code/2) cycles and the low phase lasts the remainder. Code 1 is the exception: it holds the output continuously high.
- R4: Code 0 gives a period of 32 source cycles, 16 high and 16 low.
- R5: A write to address 0 with any value outside 0xAA0..0xABF sets the divide code to 31. It also sets the bad-write flag, which is bit 24 of the status register at address 2.
- R6: The bad-write flag stays set through later valid writes and through status writes that carry 0 in bit 24. Writing a 1 to bit 24 of the status register clears it.
- R7: A new divide code takes effect only at the end of the output period in progress. The output shows only whole periods of the old ratio followed by whole periods of the new one.
- R8: A write to address 1 whose bits [11:4] equal 0xAA applies bit 3 as the output enable and bits [2:0] as a delay of the output by that many source cycles. When the enable is 0, the output is held low. The phase register reads back 0xAA0 | enable<<3 | delay.
- R9: A write to address 1 with any other value in bits [11:4] sets the output to enabled with delay 0. It does not touch the bad-write flag.
- R10: Address 3 reads as 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select: 0 divider, 1 phase, 2 status |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Write strobe, one write per cycle while high |
| reg_rdata | output | 32 | Read data for the selected register (combinational) |
| clk_out | output | 1 | Divided, delayed and gated output clock |

## Verification
The hardest case to reach is a ratio change in the middle of a period. The test has to show that no shortened high or low phase ever appears, yet the point inside the period at which the write lands cannot be seen from the ports. The bench therefore logs every completed high/low run around a mid-period rewrite. It then checks that the log contains only old-ratio periods followed only by new-ratio periods.

The output delay has no reference edge at the ports. To measure it, the bench re-applies reset and issues the phase write in the first cycle after reset. It then counts source cycles to the first falling edge of the output, whose position without delay is fixed by the reset values.

// File: rtl/pwdiv_pkg.sv
package pwdiv_pkg;

    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 2;
    localparam int CODE_W     = 5;
    localparam int SHIFT_W    = 3;
    localparam int RATIO_W    = CODE_W + 1;
    localparam int MAX_SHIFT  = (1 << SHIFT_W) - 1;

    // divider key: value bits above the code field
    localparam int DIV_KEY_W  = DATA_W - CODE_W;
    localparam logic [DIV_KEY_W-1:0] DIV_KEY = DIV_KEY_W'(12'hAA0 >> CODE_W);

    // phase key sits just above the enable bit
    localparam int PH_KEY_W   = 8;
    localparam logic [PH_KEY_W-1:0] PH_KEY = 8'hAA;
    localparam int PH_EN_BIT  = SHIFT_W;
    localparam int PH_KEY_LSB = SHIFT_W + 1;

    localparam int BAD_BIT    = 24;

    localparam logic [CODE_W-1:0] RESET_CODE    = CODE_W'(16);
    localparam logic [CODE_W-1:0] FALLBACK_CODE = '1;

    typedef enum logic [ADDR_W-1:0] {
        SEL_DIV    = 2'd0,
        SEL_PHASE  = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic               en;
        logic [SHIFT_W-1:0] shift;
    } phase_cfg_t;

    localparam phase_cfg_t PHASE_DEFAULT = '{en: 1'b1, shift: '0};

    typedef logic [RATIO_W-1:0] ratio_t;

    // code 0 stands for the largest ratio
    function automatic ratio_t ratio_of(input logic [CODE_W-1:0] code);
        return (code == '0) ? ratio_t'(1 << CODE_W) : ratio_t'(code);
    endfunction

    // high-phase length: floor(r/2), at least one cycle
    function automatic ratio_t high_of(input ratio_t r);
        return (r == ratio_t'(1)) ? ratio_t'(1) : (r >> 1);
    endfunction

    function automatic logic div_key_ok(input logic [DIV_KEY_W-1:0] upper);
        return upper == DIV_KEY;
    endfunction

    function automatic logic phase_key_ok(input logic [PH_KEY_W-1:0] key);
        return key == PH_KEY;
    endfunction

endpackage

// File: rtl/pwdiv_regs.sv
module pwdiv_regs
    import pwdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_we,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [CODE_W-1:0] div_code,
    output phase_cfg_t        phase_cfg,
    output logic              bad_flag
);

    reg_sel_e sel;
    logic     div_ok;
    logic     ph_ok;

    assign sel    = reg_sel_e'(reg_addr);
    assign div_ok = div_key_ok(reg_wdata[DATA_W-1:CODE_W]);
    assign ph_ok  = phase_key_ok(reg_wdata[PH_KEY_LSB +: PH_KEY_W]);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_code  <= RESET_CODE;
            phase_cfg <= PHASE_DEFAULT;
            bad_flag  <= 1'b0;
        end else if (reg_we) begin
            case (sel)
                SEL_DIV: begin
                    if (div_ok) begin
                        div_code <= reg_wdata[CODE_W-1:0];
                    end else begin
                        div_code <= FALLBACK_CODE;
                        bad_flag <= 1'b1;
                    end
                end
                SEL_PHASE: begin
                    if (ph_ok) begin
                        phase_cfg.en    <= reg_wdata[PH_EN_BIT];
                        phase_cfg.shift <= reg_wdata[SHIFT_W-1:0];
                    end else begin
                        phase_cfg <= PHASE_DEFAULT;
                    end
                end
                SEL_STATUS: begin
                    if (reg_wdata[BAD_BIT]) begin
                        bad_flag <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_DIV:    reg_rdata = {DIV_KEY, div_code};
            SEL_PHASE:  reg_rdata = DATA_W'({PH_KEY, phase_cfg.en, phase_cfg.shift});
            SEL_STATUS: reg_rdata[BAD_BIT] = bad_flag;
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pwdiv_core.sv
module pwdiv_core
    import pwdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code_in,
    output logic              div_q,
    output ratio_t            cur_ratio,
    output ratio_t            cnt,
    output logic              period_end
);

    ratio_t next_ratio;
    ratio_t cnt_inc;

    assign next_ratio = ratio_of(code_in);
    assign cnt_inc    = cnt + ratio_t'(1);
    assign period_end = (cnt == cur_ratio - ratio_t'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            cur_ratio <= ratio_of(RESET_CODE);
            div_q     <= 1'b1;
        end else if (period_end) begin
            // ratio is picked up only here, on a whole-period boundary
            cnt       <= '0;
            cur_ratio <= next_ratio;
            div_q     <= 1'b1;
        end else begin
            cnt       <= cnt_inc;
            div_q     <= (cnt_inc < high_of(cur_ratio));
        end
    end

endmodule

// File: rtl/pwdiv_delay.sv
module pwdiv_delay
    import pwdiv_pkg::*;
#(
    parameter int STAGES = MAX_SHIFT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               din,
    input  logic [SHIFT_W-1:0] sel,
    output logic               dout
);

    logic [STAGES:0] taps;

    assign taps[0] = din;

    for (genvar i = 1; i <= STAGES; i++) begin : g_stage
        logic q;
        always_ff @(posedge clk) begin
            if (rst) q <= 1'b0;
            else     q <= taps[i-1];
        end
        assign taps[i] = q;
    end

    assign dout = taps[sel];

endmodule

// File: rtl/pwdiv_top.sv
module pwdiv_top
    import pwdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_we,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              clk_out
);

    logic [CODE_W-1:0] div_code;
    phase_cfg_t        phase_cfg;
    logic              bad_flag;
    logic              div_q;
    ratio_t            cur_ratio;
    ratio_t            cnt;
    logic              period_end;
    logic              delayed;

    pwdiv_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata),
        .div_code  (div_code),
        .phase_cfg (phase_cfg),
        .bad_flag  (bad_flag)
    );

    pwdiv_core u_core (
        .clk        (clk),
        .rst        (rst),
        .code_in    (div_code),
        .div_q      (div_q),
        .cur_ratio  (cur_ratio),
        .cnt        (cnt),
        .period_end (period_end)
    );

    pwdiv_delay #(.STAGES(MAX_SHIFT)) u_delay (
        .clk  (clk),
        .rst  (rst),
        .din  (div_q),
        .sel  (phase_cfg.shift),
        .dout (delayed)
    );

    assign clk_out = phase_cfg.en & delayed;

endmodule

// File: rtl/pwdiv_chk.sv
module pwdiv_chk
    import pwdiv_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              reg_we,
    input logic [CODE_W-1:0] div_code,
    input logic              bad_flag,
    input ratio_t            cur_ratio,
    input ratio_t            cnt,
    input logic              period_end,
    input phase_cfg_t        phase_cfg
);

    logic div_wr, st_clr, ph_wr;

    assign div_wr = reg_we && (reg_addr == ADDR_W'(SEL_DIV));
    assign ph_wr  = reg_we && (reg_addr == ADDR_W'(SEL_PHASE));
    assign st_clr = reg_we && (reg_addr == ADDR_W'(SEL_STATUS)) && reg_wdata[BAD_BIT];

    // R2
    valid_code_store_chk: assert property (@(posedge clk) disable iff (rst)
        (div_wr && reg_wdata[DATA_W-1:CODE_W] == DIV_KEY)
        |=> div_code == $past(reg_wdata[CODE_W-1:0]));

    // R5
    bad_write_fallback_chk: assert property (@(posedge clk) disable iff (rst)
        (div_wr && reg_wdata[DATA_W-1:CODE_W] != DIV_KEY)
        |=> (bad_flag && div_code == FALLBACK_CODE));

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (bad_flag && !st_clr) |=> bad_flag);

    // R7
    ratio_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        !period_end |=> $stable(cur_ratio));

    // R3
    cnt_in_period_chk: assert property (@(posedge clk) disable iff (rst)
        cnt < cur_ratio);

    // R9
    phase_fallback_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_wr && reg_wdata[PH_KEY_LSB +: PH_KEY_W] != PH_KEY)
        |=> (phase_cfg.en && phase_cfg.shift == '0));

endmodule

bind pwdiv_top pwdiv_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_we     (reg_we),
    .div_code   (div_code),
    .bad_flag   (bad_flag),
    .cur_ratio  (cur_ratio),
    .cnt        (cnt),
    .period_end (period_end),
    .phase_cfg  (phase_cfg)
);

// File: tb/pwdiv_top_test.sv
`timescale 1ns/1ps
module pwdiv_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_rdata;
    logic        clk_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    pwdiv_top uut (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata),
        .clk_out   (clk_out)
    );

    typedef struct {
        int    hi;
        int    lo;
        string req;
    } period_t;

    period_t exp_q[$];
    int      log_hi[$];
    int      log_lo[$];
    bit      log_on = 0;
    bit      mon_restart = 0;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor: measures high/low runs between rising edges, at negedge
    bit mon_started = 0;
    bit mon_prev = 0;
    int mon_hi = 0;
    int mon_lo = 0;
    always @(negedge clk) begin
        if (rst) begin
            mon_started = 0;
            mon_prev    = 0;
        end else begin
            if (mon_restart) begin
                mon_started = 0;
                mon_restart = 0;
            end
            if (clk_out && !mon_prev) begin
                if (mon_started) begin
                    if (log_on) begin
                        log_hi.push_back(mon_hi);
                        log_lo.push_back(mon_lo);
                    end
                    if (exp_q.size() > 0) begin
                        period_t e;
                        e = exp_q.pop_front();
                        check(e.req, "high run", mon_hi, e.hi);
                        check(e.req, "low run", mon_lo, e.lo);
                    end
                end
                mon_started = 1;
                mon_hi = 1;
                mon_lo = 0;
            end else if (mon_started) begin
                if (clk_out) mon_hi++;
                else         mon_lo++;
            end
            mon_prev = clk_out;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #3;
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(posedge clk); #3;
        reg_we = 1'b0;
    endtask

    task automatic rd_check(input logic [1:0] a, input logic [31:0] exp, input string req);
        @(posedge clk); #3;
        reg_addr = a;
        #1;
        check(req, $sformatf("read addr %0d", a), reg_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    // driver: queue expected whole periods for the monitor
    task automatic expect_periods(input int hi, input int lo, input int k, input string req);
        @(posedge clk); #3;
        mon_restart = 1;
        for (int i = 0; i < k; i++) exp_q.push_back('{hi: hi, lo: lo, req: req});
        while (exp_q.size() > 0) @(posedge clk);
    endtask

    // reset, phase write in first cycle, count cycles to first falling edge
    task automatic phase_probe(input logic [31:0] w, input int exp_fall,
                               input int exp_ones_zero, input string req);
        int fall = -1;
        int ones = 0;
        bit prev = 0;
        @(posedge clk); #3;
        rst = 1'b1;
        idle(2); #3;
        rst = 1'b0; reg_addr = 2'd1; reg_wdata = w; reg_we = 1'b1;
        for (int k = 1; k <= 40; k++) begin
            @(posedge clk); #3;
            if (k == 1) reg_we = 1'b0;
            if (clk_out) ones++;
            if (fall < 0 && prev && !clk_out) fall = k;
            prev = clk_out;
        end
        check(req, $sformatf("first fall for %0h", w), fall, exp_fall);
        if (exp_ones_zero != 0) check(req, "output held low", ones, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=expired expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        bit order_ok;
        bit seen_new;
        int n_old;
        int n_new;
        idle(4); #3;
        rst = 1'b0;

        // R1 reset state
        rd_check(2'd0, 32'h0000_0AB0, "R1");
        rd_check(2'd1, 32'h0000_0AA8, "R1");
        rd_check(2'd2, 32'h0, "R1");
        expect_periods(8, 8, 3, "R1");

        // R2 / R3 valid codes
        wr(2'd0, 32'h0000_0AA5);
        rd_check(2'd0, 32'h0000_0AA5, "R2");
        idle(70);
        expect_periods(2, 3, 4, "R3");
        wr(2'd0, 32'h0000_0ABF);
        idle(70);
        expect_periods(15, 16, 2, "R3");
        wr(2'd0, 32'h0000_0AA2);
        idle(70);
        expect_periods(1, 1, 4, "R3");

        // R4 code zero
        wr(2'd0, 32'h0000_0AA0);
        rd_check(2'd0, 32'h0000_0AA0, "R4");
        idle(70);
        expect_periods(16, 16, 2, "R4");

        // R3 code one holds output high
        wr(2'd0, 32'h0000_0AA1);
        idle(70);
        begin
            int lows = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (!clk_out) lows++;
            end
            check("R3", "code 1 low samples", lows, 0);
        end
        rd_check(2'd2, 32'h0, "R6");

        // R5 invalid writes, both sides of the key range
        wr(2'd0, 32'h0000_1234);
        rd_check(2'd0, 32'h0000_0ABF, "R5");
        rd_check(2'd2, 32'h0100_0000, "R5");
        idle(70);
        expect_periods(15, 16, 2, "R5");
        wr(2'd2, 32'h0100_0000);
        wr(2'd0, 32'h0000_0AA3);
        wr(2'd0, 32'h0000_0AC0);
        rd_check(2'd0, 32'h0000_0ABF, "R5");
        wr(2'd0, 32'h0000_0AA3);
        wr(2'd0, 32'h0000_0A9F);
        rd_check(2'd0, 32'h0000_0ABF, "R5");

        // R6 sticky flag and one-to-clear
        wr(2'd0, 32'h0000_0AA4);
        rd_check(2'd2, 32'h0100_0000, "R6");
        wr(2'd2, 32'hFEFF_FFFF);
        rd_check(2'd2, 32'h0100_0000, "R6");
        wr(2'd2, 32'h0100_0000);
        rd_check(2'd2, 32'h0, "R6");

        // R10 unmapped address
        wr(2'd3, 32'h0000_1234);
        rd_check(2'd0, 32'h0000_0AA4, "R10");
        rd_check(2'd2, 32'h0, "R10");
        rd_check(2'd3, 32'h0, "R10");

        // R7 mid-period change: only whole old then whole new periods
        idle(40);
        @(posedge clk); #3;
        log_on = 1;
        idle(23);
        wr(2'd0, 32'h0000_0AAA);
        idle(80);
        @(posedge clk); #3;
        log_on = 0;
        order_ok = 1; seen_new = 0; n_old = 0; n_new = 0;
        foreach (log_hi[i]) begin
            if (log_hi[i] == 2 && log_lo[i] == 2) begin
                n_old++;
                if (seen_new) order_ok = 0;
            end else if (log_hi[i] == 5 && log_lo[i] == 5) begin
                n_new++;
                seen_new = 1;
            end else begin
                order_ok = 0;
            end
        end
        check("R7", "only whole periods, old before new", order_ok, 1);
        check("R7", "old periods seen", n_old > 0, 1);
        check("R7", "new periods seen", n_new > 0, 1);

        // R8 / R9 phase control
        phase_probe(32'h0000_0AA8, 8, 0, "R8");
        phase_probe(32'h0000_0AAB, 11, 0, "R8");
        rd_check(2'd1, 32'h0000_0AAB, "R8");
        phase_probe(32'h0000_0AAF, 15, 0, "R8");
        phase_probe(32'h0000_0AA3, -1, 1, "R8");
        rd_check(2'd1, 32'h0000_0AA3, "R8");
        phase_probe(32'h0000_055B, 8, 0, "R9");
        rd_check(2'd1, 32'h0000_0AA8, "R9");
        rd_check(2'd2, 32'h0, "R9");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule